// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block produces the single-cycle pulse that paces a UART transmitter and receiver at sixteen times the bit rate. One 16-bit rate word feeds it, and a mode input decides how that word is read. In integer mode the word is a divisor: a down-counter is loaded from it and the block pulses each time the counter runs out. In accumulator mode the same word is an increment: it is added to a 16-bit phase register on every clock, and each carry out of the top bit is one pulse. The integer mode suits low bit rates, where the clock-to-rate ratio is large and a whole-number divisor is accurate enough. The accumulator mode suits higher rates, where rounding a small divisor would cost too much accuracy.

For integer mode the word is set to f_clk / (16 × baud). For accumulator mode it is set to baud × 16 × 65536 / f_clk. A run input gates the whole generator. While run is low, both the counter and the phase register are held at zero and no pulse leaves the block. That is the port's lowest-power state. Enabling the block, or switching modes, restarts timing from zero, so the first pulse comes one full period later.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_ni is low, tick_o is 0, whatever the other inputs do.
- R2: While run_i is low, tick_o stays 0 from the first clock edge after run_i falls. Changes to baud_val_i or frac_mode_i during that time have no effect.
- R3: In integer mode (frac_mode_i = 0) with a steady divisor D ≥ 2, tick_o pulses for one cycle every D cycles.
- R4: In integer mode, a divisor of 0 or 1 makes tick_o high on every cycle once the first pulse has arrived, and never stalls it.
- R5: Count the clock edges from the first edge that samples run_i high, starting at edge 1. In integer mode the first pulse is visible after edge max(D,1)+1. Stopping and starting again restarts this count.
- R6: In integer mode, a new divisor written after a pulse does not shorten or lengthen the period already under way. It sets the length of the period after that one.
- R7: In accumulator mode (frac_mode_i = 1) with increment I, tick_o is high after edge k exactly when floor(k·I/65536) > floor((k−1)·I/65536). An increment of 0 gives no pulses.
- R8: In accumulator mode, a new increment is added from the very next clock edge, and the phase already built up is kept.
- R9: frac_mode_i selects the mode: 0 is integer divide, 1 is accumulator. A change of mode restarts the newly selected path from zero, and only that path can produce pulses.
- R10: In accumulator mode with an increment below 32768, two pulses are never on consecutive cycles. In integer mode with D ≥ 2, they are never consecutive either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Generator enable; low holds all timing state at zero |
| frac_mode_i | input | 1 | 0 = integer divisor, 1 = phase-accumulator increment |
| baud_val_i | input | 16 | Rate word (divisor or increment, depending on mode) |
| tick_o | output | 1 | One-cycle 16x oversampling pulse |

## Verification
Two events can land in the same cycle: the counter reload and a new rate word. In accumulator mode the same is true of the carry and a new increment. The bench changes the word on the edge that follows a pulse. It then checks that the integer period in progress keeps its old length, and that the accumulator adopts the new increment on the very next step without losing phase. A mode change is also made in the middle of a period, and the bench judges it by where the first pulse of the newly selected path falls.

// File: rtl/bg_pkg.sv
package bg_pkg;

  typedef enum logic {
    BG_MODE_INT  = 1'b0,
    BG_MODE_FRAC = 1'b1
  } bg_mode_e;

  // Value loaded into the down-counter for a divisor; 0 and 1 both mean
  // "expire every cycle".
  function automatic logic [31:0] bg_reload(input logic [31:0] div);
    return (div <= 32'd1) ? 32'd0 : div - 32'd1;
  endfunction

endpackage

// File: rtl/bg_div_counter.sv
module bg_div_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         expire_o
);
  import bg_pkg::*;

  logic [W-1:0] cnt_q;
  logic         armed_q;
  logic         reload;

  assign expire_o = en_i && armed_q && (cnt_q == '0);
  assign reload   = !armed_q || (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (reload) cnt_q <= W'(bg_reload(32'(div_i)));
      else        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bg_phase_acc.sv
module bg_phase_acc #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] inc_i,
  output logic         expire_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum      = {1'b0, acc_q} + {1'b0, inc_i};
  assign expire_o = en_i && sum[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= sum[W-1:0];
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         frac_mode_i,
  input  logic [W-1:0] baud_val_i,
  output logic         tick_o
);
  import bg_pkg::*;

  bg_mode_e mode;
  logic     int_en;
  logic     frac_en;
  logic     int_expire;
  logic     frac_expire;
  logic     tick_q;

  assign mode    = bg_mode_e'(frac_mode_i);
  assign int_en  = run_i && (mode == BG_MODE_INT);
  assign frac_en = run_i && (mode == BG_MODE_FRAC);

  bg_div_counter #(.W(W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (int_en),
    .div_i    (baud_val_i),
    .expire_o (int_expire)
  );

  bg_phase_acc #(.W(W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (frac_en),
    .inc_i    (baud_val_i),
    .expire_o (frac_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= (mode == BG_MODE_FRAC) ? frac_expire : int_expire;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/bg_chk.sv
module bg_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic         frac_mode_i,
  input logic [W-1:0] baud_val_i,
  input logic         tick_o,
  input logic         int_expire,
  input logic         frac_expire
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> !tick_o); // R1

  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_o); // R2

  AST_INT_TO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_expire && !frac_mode_i) |=> tick_o); // R3

  AST_FRAC_TO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_expire && frac_mode_i) |=> tick_o); // R7

  AST_PATH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(int_expire && frac_expire)); // R9

  AST_INT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_expire && (baud_val_i >= W'(2))) |=> !int_expire); // R10

  AST_FRAC_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && frac_mode_i && !baud_val_i[W-1] && $stable(baud_val_i))
      |-> !frac_expire); // R10
endmodule

bind baud_tick_gen bg_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .frac_mode_i (frac_mode_i),
  .baud_val_i  (baud_val_i),
  .tick_o      (tick_o),
  .int_expire  (int_expire),
  .frac_expire (frac_expire)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         run = 1'b0;
  logic         fmode = 1'b0;
  logic [W-1:0] bval = '0;
  logic         tick;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  baud_tick_gen #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run),
    .frac_mode_i(fmode), .baud_val_i(bval), .tick_o(tick)
  );

  // Expected tick after running edge k.
  // sel 0: none; 1: integer period a (change to b after edge cg);
  // 2: accumulator, increment a then b after edge cg.
  function automatic bit expect_tick(int sel, int k, int a, int b, int cg);
    longint t1, t0;
    int p, q, first;
    if (sel == 0) return 1'b0;
    if (sel == 1) begin
      p = (a < 1) ? 1 : a;
      q = (b < 1) ? 1 : b;
      first = p + 1;
      if (k < first) return 1'b0;
      if (cg == 0 || k <= first + p) begin
        if (cg == 0) return ((k - first) % p) == 0;
        if (k == first || k == first + p) return 1'b1;
        return 1'b0;
      end
      return ((k - (first + p)) % q) == 0;
    end
    t1 = (cg == 0 || k <= cg) ? longint'(k) * a : longint'(cg) * a + longint'(k - cg) * b;
    t0 = (cg == 0 || k - 1 <= cg) ? longint'(k - 1) * a : longint'(cg) * a + longint'(k - 1 - cg) * b;
    return (t1 >> 16) != (t0 >> 16);
  endfunction

  task automatic observe(string req, int n, int sel, int a, int b, int cg);
    bit bad = 0;
    int bk = 0;
    bit ba = 0, be = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (tick !== expect_tick(sel, k, a, b, cg) && !bad) begin
        bad = 1; bk = k; ba = tick; be = expect_tick(sel, k, a, b, cg);
      end
      if (cg != 0 && k == cg) bval = W'(b);
    end
    checks++;
    if (bad) begin
      errs++;
      $display("FAIL %s: cycle %0d tick actual=%0b expected=%0b", req, bk, ba, be);
    end
  endtask

  task automatic start(bit m, int v);
    @(negedge clk);
    fmode = m; bval = W'(v); run = 1'b1;
  endtask

  task automatic halt();
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    bit bad = 0;
    run = 1'b1; bval = W'(1); fmode = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tick !== 1'b0) bad = 1;
    end
    checks++;
    if (bad) begin errs++; $display("FAIL R1: tick actual=1 expected=0 in reset"); end
    run = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_idle();
    @(negedge clk); bval = W'(1); fmode = 1'b0;
    observe("R2 idle int", 10, 0, 0, 0, 0);
    @(negedge clk); bval = W'(40000); fmode = 1'b1;
    observe("R2 idle frac", 10, 0, 0, 0, 0);
  endtask

  task automatic t_int(int d, string req);
    start(1'b0, d);
    observe(req, 4 * ((d < 1) ? 1 : d) + 8, 1, d, 0, 0);
    halt();
  endtask

  task automatic t_frac(int inc, string req);
    start(1'b1, inc);
    observe(req, 120, 2, inc, 0, 0);
    halt();
  endtask

  task automatic t_stop_restart();
    start(1'b0, 3);
    observe("R3 before stop", 10, 1, 3, 0, 0);
    @(negedge clk); run = 1'b0; bval = W'(1); fmode = 1'b1;
    @(negedge clk); bval = W'(2); fmode = 1'b0;
    observe("R2 stopped", 15, 0, 0, 0, 0);
    start(1'b0, 4);
    observe("R5 restart", 17, 1, 4, 0, 0);
    halt();
  endtask

  task automatic t_int_change();
    start(1'b0, 6);
    observe("R6 divisor change", 25, 1, 6, 3, 7);
    halt();
  endtask

  task automatic t_frac_change();
    start(1'b1, 8192);
    observe("R8 increment change", 24, 2, 8192, 16384, 8);
    halt();
  endtask

  task automatic t_mode_switch();
    start(1'b0, 4);
    repeat (6) @(negedge clk);
    fmode = 1'b1; bval = W'(16384);
    observe("R9 switch to accumulator", 16, 2, 16384, 0, 0);
    fmode = 1'b0; bval = W'(4);
    observe("R9 switch to integer", 17, 1, 4, 0, 0);
    halt();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_int(5, "R3 R5 D=5");
    t_int(2, "R3 R10 D=2");
    t_int(1, "R4 D=1");
    t_int(0, "R4 D=0");
    t_frac(4096, "R7 inc=4096");
    t_frac(30000, "R7 R10 inc=30000");
    t_frac(0, "R7 inc=0");
    t_stop_restart();
    t_int_change();
    t_frac_change();
    t_mode_switch();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule